// File: doc/BRIEF.md
# Fractional Pixel-Rate Strobe Generator

This block derives a pixel-rate enable strobe from a faster clock. The strobe is not a clock. Two tick inputs mark the edges of two candidate source rates, both carried in the `clk` domain. One of them is the main source and the other is an alternate high-speed source. A 32-bit configuration word chooses the source, sets an integer divisor and sets a 12-bit fractional value.

The integer stage counts ticks of the chosen source. It raises an intermediate pulse every divisor ticks. The fractional stage is a 12-bit phase accumulator. On each intermediate pulse it adds the fractional value, and it suppresses that pulse when the addition carries out. The output rate is therefore the source rate / divisor × (1 − frac/4096).

A write to the configuration word lands in a pending copy. The running settings take that copy only at an integer-stage terminal count, so a period is never cut short. The control pins are plain. There is no stream interface and no back-pressure.

Top module: `pxdiv_strobe_gen`

## Requirements
- R1: After reset, `pix_en` is low. The running settings are divisor 2, fractional value 0 and the main source, so a pulse follows every 2nd main tick.
- R2: With fractional value 0, exactly one `pix_en` pulse follows every N-th tick of the selected source. N is the integer field, `cfg_wdata[DIV_W-1:0]`.
- R3: An integer field of 0 or 1 behaves as a divisor of 2.
- R4: The fractional field is `cfg_wdata[27:16]`. On each intermediate pulse it is added to a 12-bit accumulator, which starts at 0 after reset. The pulse is removed when that sum is 4096 or more. A value of 0 removes nothing.
- R5: `cfg_wdata[31]` = 1 selects `tick_alt`, and `tick_main` then has no effect. When the bit is 0 the reverse holds.
- R6: A write takes effect at the next terminal count after the write cycle. A write in the same cycle as a terminal count waits for the following one. A period that is already running always completes with its old divisor.
- R7: `pix_en` is high for exactly one `clk` cycle. It is high in the cycle after the clock edge at which the terminal tick was sampled, and never high without such a tick.
- R8: Bits 30:28 and bits 15:DIV_W of the configuration word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that carries both source ticks |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word: bit 31 source select, 27:16 fraction, DIV_W-1:0 divisor |
| tick_main | input | 1 | One-cycle tick of the main source rate |
| tick_alt | input | 1 | One-cycle tick of the alternate high-speed source rate |
| pix_en | output | 1 | One-cycle pixel enable strobe |

## Verification
Two events can fall in the same cycle, and each pairing is provoked on purpose and judged by the position of every later pulse. The first pairing is a configuration write that lands on the cycle of a terminal count. The bench drives the write together with the terminal tick. It expects that terminal pulse and the whole next period to use the old divisor, and the divisor after that to be the new one. The second pairing is a terminal count that coincides with an accumulator carry. A fraction of 2048 or 3072 is chosen so that known intermediate pulses carry, and exactly those pulses must be missing from `pix_en`.

// File: rtl/pxdiv_pkg.sv
package pxdiv_pkg;
  localparam int CFG_W    = 32;
  localparam int SEL_BIT  = 31;
  localparam int FRAC_W   = 12;
  localparam int FRAC_LSB = 16;
  localparam int MIN_DIV  = 2;
endpackage

// File: rtl/pxdiv_cfg.sv
module pxdiv_cfg
  import pxdiv_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_W-1:0]  wdata,
  input  logic              load,
  output logic [DIV_W-1:0]  act_last,
  output logic [FRAC_W-1:0] act_frac,
  output logic              act_sel
);
  localparam logic [DIV_W-1:0] MIN_D   = DIV_W'(MIN_DIV);
  localparam logic [DIV_W-1:0] RST_LAST = DIV_W'(MIN_DIV - 1);

  logic [DIV_W-1:0]  pend_last;
  logic [FRAC_W-1:0] pend_frac;
  logic              pend_sel;
  logic [DIV_W-1:0]  w_div;
  logic [DIV_W-1:0]  w_eff;

  always_comb begin
    w_div = wdata[DIV_W-1:0];
    w_eff = (w_div < MIN_D) ? MIN_D : w_div;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_last <= RST_LAST;
      pend_frac <= '0;
      pend_sel  <= 1'b0;
    end else if (we) begin
      pend_last <= w_eff - 1'b1;
      pend_frac <= wdata[FRAC_LSB +: FRAC_W];
      pend_sel  <= wdata[SEL_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_last <= RST_LAST;
      act_frac <= '0;
      act_sel  <= 1'b0;
    end else if (load) begin
      act_last <= pend_last;
      act_frac <= pend_frac;
      act_sel  <= pend_sel;
    end
  end

  // R6
  settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({act_last, act_frac, act_sel}));

  // R3
  min_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_last != '0);
endmodule

// File: rtl/pxdiv_count.sv
module pxdiv_count #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [DIV_W-1:0] last,
  output logic             tc
);
  logic [DIV_W-1:0] cnt;

  assign tc = tick && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (tc)     cnt <= '0;
    else if (tick)   cnt <= cnt + 1'b1;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last);
endmodule

// File: rtl/pxdiv_frac.sv
module pxdiv_frac
  import pxdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse,
  input  logic [FRAC_W-1:0] frac,
  output logic              en
);
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   sum;

  assign sum = {1'b0, acc} + {1'b0, frac};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      en  <= 1'b0;
    end else begin
      en <= pulse && !sum[FRAC_W];
      if (pulse) acc <= sum[FRAC_W-1:0];
    end
  end

  // R4
  zero_frac_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && frac == '0) |=> en);
endmodule

// File: rtl/pxdiv_strobe_gen.sv
module pxdiv_strobe_gen
  import pxdiv_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             tick_main,
  input  logic             tick_alt,
  output logic             pix_en
);
  logic [DIV_W-1:0]  act_last;
  logic [FRAC_W-1:0] act_frac;
  logic              act_sel;
  logic              tick_sel;
  logic              tc;

  assign tick_sel = act_sel ? tick_alt : tick_main;

  pxdiv_cfg #(.DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .load(tc),
    .act_last(act_last), .act_frac(act_frac), .act_sel(act_sel)
  );

  pxdiv_count #(.DIV_W(DIV_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick_sel), .last(act_last), .tc(tc)
  );

  pxdiv_frac u_frac (
    .clk(clk), .rst_n(rst_n), .pulse(tc), .frac(act_frac), .en(pix_en)
  );

  // R7
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> !pix_en);

  // R7
  tick_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_en) |-> $past(tick_sel));
endmodule

// File: tb/test_pxdiv_strobe_gen.sv
module test_pxdiv_strobe_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        tick_main = 1'b0;
  logic        tick_alt = 1'b0;
  logic        pix_en;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pxdiv_strobe_gen i_pxdiv_strobe_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tick_main(tick_main), .tick_alt(tick_alt), .pix_en(pix_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; tick_main = 1'b0; tick_alt = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg_write(input logic [31:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // n steps, each with the given ticks; pulses expected at steps p0,p1,p2 (0 = none)
  task automatic run(input int n, input bit m, input bit a,
                     input int p0, input int p1, input int p2, input string req);
    for (int k = 1; k <= n; k++) begin
      bit exp;
      tick_main = m; tick_alt = a;
      @(posedge clk); @(negedge clk);
      exp = (k == p0) || (k == p1) || (k == p2);
      chk(pix_en == exp, $sformatf("%s step %0d", req, k), pix_en, exp);
    end
    tick_main = 1'b0; tick_alt = 1'b0;
  endtask

  task automatic prime(input logic [31:0] d);
    do_reset();
    cfg_write(d);
    run(2, 1'b1, 1'b0, 2, 0, 0, "R1 prime");
  endtask

  task automatic t_reset();
    do_reset();
    chk(pix_en == 1'b0, "R1 reset level", pix_en, 0);
    run(6, 1'b0, 1'b0, 0, 0, 0, "R7 idle");
    run(4, 1'b1, 1'b0, 2, 4, 0, "R1 default div");
  endtask

  task automatic t_int_div();
    prime(32'd5);
    run(15, 1'b1, 1'b0, 5, 10, 15, "R2 div5");
    run(3, 1'b0, 1'b0, 0, 0, 0, "R7 no tick");
  endtask

  task automatic t_small_div();
    prime(32'd0);
    run(6, 1'b1, 1'b0, 2, 4, 6, "R3 div0");
    prime(32'd1);
    run(6, 1'b1, 1'b0, 2, 4, 6, "R3 div1");
  endtask

  task automatic t_frac();
    prime(32'h0800_0003);
    run(12, 1'b1, 1'b0, 3, 9, 0, "R4 frac2048");
    prime(32'h0C00_0002);
    run(16, 1'b1, 1'b0, 2, 10, 0, "R4 frac3072");
  endtask

  task automatic t_select();
    prime(32'h8000_0003);
    run(6, 1'b1, 1'b0, 0, 0, 0, "R5 main ignored");
    run(6, 1'b0, 1'b1, 3, 6, 0, "R5 alt source");
  endtask

  task automatic t_write_timing();
    prime(32'd4);
    run(3, 1'b1, 1'b0, 0, 0, 0, "R6 pre");
    tick_main = 1'b1; cfg_we = 1'b1; cfg_wdata = 32'd2;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0; tick_main = 1'b0;
    chk(pix_en == 1'b1, "R6 tc with write", pix_en, 1);
    run(8, 1'b1, 1'b0, 4, 6, 8, "R6 write on tc");
    prime(32'd6);
    run(2, 1'b1, 1'b0, 0, 0, 0, "R6 mid pre");
    cfg_write(32'd2);
    run(8, 1'b1, 1'b0, 4, 6, 8, "R6 mid write");
  endtask

  task automatic t_reserved();
    prime(32'h7000_F003);
    run(6, 1'b1, 1'b0, 3, 6, 0, "R8 reserved bits");
  endtask

  initial begin
    #4ms;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_int_div();
    t_small_div();
    t_frac();
    t_select();
    t_write_timing();
    t_reserved();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule